// File: doc/BRIEF.md
# Vector carry-less multiply-sum unit

This block multiplies two 128-bit vectors element by element over GF(2), so partial products are combined with XOR and no carries form. The operands are split into equal-width elements of 8, 16, 32 or 64 bits, which gives 16, 8, 4 or 2 lanes. Each lane yields a product twice the element width. The products of each adjacent pair of lanes are then XORed into one double-width result element. The result therefore has half as many elements as the sources, and it still fills 128 bits.

An operation code picks the element width. An operation is issued by raising `in_valid_i` with legal operands. The result appears two cycles later, and a new operation may be issued on every cycle. The block performs no modular reduction. A code outside the legal set is dropped, so no valid result is produced for it.

Top module: `clmul_sum_unit`

## Requirements
- R1: Code 16 selects 8-bit elements. Lane k holds bits [127-8k:120-8k] of each source, and result element i holds bits [127-16i:112-16i]. Each result element equals clmul(lane 2i) XOR clmul(lane 2i+1).
- R2: Code 17 selects 16-bit elements and 32-bit result elements, with the same pairing as R1.
- R3: Code 18 selects 32-bit elements and 64-bit result elements, with the same pairing as R1.
- R4: Code 19 selects 64-bit elements. The two 128-bit lane products are XORed into one 128-bit result.
- R5: Numbering runs from the most significant end of the vector. A product of lane 0 in byte mode lands in result bits [127:112].
- R6: The top bit of every lane product is zero, so the top bit of every valid result element is zero.
- R7: Any code other than 16 to 19 produces neither a valid output nor a nonzero result.
- R8: A legal issue gives `out_valid_o` exactly two cycles later, and issues on consecutive cycles give results on consecutive cycles.
- R9: While `rst_ni` is low, `out_valid_o` is 0 and `result_o` is 0.
- R10: `result_o` is zero whenever `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Issue strobe |
| op_i | input | 5 | Operation code (16 byte, 17 halfword, 18 word, 19 doubleword) |
| src_a_i | input | 128 | Multiplier vector |
| src_b_i | input | 128 | Multiplicand vector |
| out_valid_o | output | 1 | Result strobe, two cycles after issue |
| result_o | output | 128 | Pairwise XOR of lane products |

## Verification
Random operands in all four widths are streamed back to back, with bubbles and illegal codes mixed in. Each result is compared against a bit-serial model. All-ones multipliers against alternating all-ones and zero multiplicands yield known patterns such as 0x5555, which separates a correct carry-less product from an ordinary one that carries. Multipliers with only the top bit set expose shift-range errors at the widest shift. A lone product in lane 0 and zero operands pin down lane ordering and pair folding, and show that an empty operand yields a zero result.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int unsigned ELEM_MIN  = 8;
  localparam int unsigned NUM_MODES = 4;
  localparam logic [4:0]  OP_BASE   = 5'd16;

  typedef enum logic [1:0] {ESZ_B = 2'd0, ESZ_H = 2'd1, ESZ_W = 2'd2, ESZ_D = 2'd3} esz_e;
endpackage

// File: rtl/clmul_lane.sv
module clmul_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  always_comb begin
    p_o = '0;
    for (int j = 0; j < W; j++) begin
      if (a_i[j]) p_o = p_o ^ ({{W{1'b0}}, b_i} << j);
    end
  end
endmodule

// File: rtl/clmul_prod_stage.sv
module clmul_prod_stage
  import clmul_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned OP_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  output logic               vld_o,
  output esz_e               esz_o,
  output logic [2*VEC_W-1:0] prod_o
);
  localparam int unsigned PW = 2 * VEC_W;

  logic [NUM_MODES-1:0][PW-1:0] prod_m;
  logic legal, accept;
  logic vld_q;
  esz_e esz_q;
  logic [PW-1:0] prod_q;

  assign legal  = (op_i >= OP_W'(OP_BASE)) && (op_i <= OP_W'(OP_BASE + 5'd3));
  assign accept = vld_i && legal;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int unsigned W     = ELEM_MIN << m;
    localparam int unsigned LANES = VEC_W / W;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [2*W-1:0] p;
      clmul_lane #(.W(W)) u_lane (
        .a_i(a_i[VEC_W-1-k*W -: W]),
        .b_i(b_i[VEC_W-1-k*W -: W]),
        .p_o(p)
      );
      assign prod_m[m][PW-1-k*2*W -: 2*W] = p;
      // lane product degree is at most 2W-2
      p_lane_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && esz_q == esz_e'(m)) |-> !prod_q[PW-1-k*2*W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      esz_q  <= ESZ_B;
      prod_q <= '0;
    end else begin
      vld_q <= accept;
      if (accept) begin
        esz_q  <= esz_e'(op_i[1:0]);
        prod_q <= prod_m[op_i[1:0]];
      end
    end
  end

  assign vld_o  = vld_q;
  assign esz_o  = esz_q;
  assign prod_o = prod_q;

  p_illegal_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (op_i < OP_W'(16) || op_i > OP_W'(19))) |=> !vld_o);
endmodule

// File: rtl/clmul_fold_stage.sv
module clmul_fold_stage
  import clmul_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  esz_e               esz_i,
  input  logic [2*VEC_W-1:0] prod_i,
  output logic               vld_o,
  output logic [VEC_W-1:0]   res_o
);
  localparam int unsigned PW = 2 * VEC_W;

  logic [NUM_MODES-1:0][VEC_W-1:0] fold_m;
  logic             vld_q;
  logic [VEC_W-1:0] res_q;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int unsigned W    = ELEM_MIN << m;
    localparam int unsigned OUTS = VEC_W / (2 * W);
    for (genvar i = 0; i < OUTS; i++) begin : g_pair
      assign fold_m[m][VEC_W-1-i*2*W -: 2*W] =
        prod_i[PW-1-(2*i)*2*W -: 2*W] ^ prod_i[PW-1-(2*i+1)*2*W -: 2*W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_i;
      res_q <= vld_i ? fold_m[esz_i] : '0;
    end
  end

  assign vld_o = vld_q;
  assign res_o = res_q;
endmodule

// File: rtl/clmul_sum_unit.sv
module clmul_sum_unit
  import clmul_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned OP_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] result_o
);
  logic               s1_vld;
  esz_e               s1_esz;
  logic [2*VEC_W-1:0] s1_prod;

  clmul_prod_stage #(.VEC_W(VEC_W), .OP_W(OP_W)) u_prod (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (in_valid_i),
    .op_i  (op_i),
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .vld_o (s1_vld),
    .esz_o (s1_esz),
    .prod_o(s1_prod)
  );

  clmul_fold_stage #(.VEC_W(VEC_W)) u_fold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (s1_vld),
    .esz_i (s1_esz),
    .prod_i(s1_prod),
    .vld_o (out_valid_o),
    .res_o (result_o)
  );

  p_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i >= OP_W'(16) && op_i <= OP_W'(19)) |=> s1_vld);

  p_pipe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == $past(s1_vld));

  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (result_o == '0));
endmodule

// File: tb/clmul_sum_unit_tb.sv
`timescale 1ns/1ps
module clmul_sum_unit_tb;
  localparam int MAXS  = 256;
  localparam int N_TAB = 12;

  localparam logic [4:0] TAB_OP [N_TAB] = '{
    5'd16, 5'd17, 5'd18, 5'd19, 5'd16, 5'd17, 5'd18, 5'd19, 5'd19, 5'd17, 5'd7, 5'd20};
  localparam logic [127:0] TAB_A [N_TAB] = '{
    {128{1'b1}}, {128{1'b1}}, {128{1'b1}}, {128{1'b1}},
    {16{8'h80}}, {8{16'h8000}}, {4{32'h8000_0000}}, {2{64'h8000_0000_0000_0000}},
    128'h0, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
    {128{1'b1}}, {128{1'b1}}};
  localparam logic [127:0] TAB_B [N_TAB] = '{
    {8{16'hff00}}, {4{32'hffff_0000}}, {2{64'hffff_ffff_0000_0000}}, {{64{1'b1}}, 64'h0},
    {8{16'hff00}}, {4{32'hffff_0000}}, {2{64'hffff_ffff_0000_0000}}, {{64{1'b1}}, 64'h0},
    128'hdead_beef_cafe_f00d_1234_5678_9abc_def0, 128'h0,
    {128{1'b1}}, {128{1'b1}}};

  logic clk = 1'b0, rst_ni = 1'b0, in_valid = 1'b0;
  logic [4:0] op = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic out_valid;
  logic [127:0] result;
  int n_chk = 0, n_bad = 0;

  logic [4:0]   s_op  [MAXS];
  logic [127:0] s_a   [MAXS];
  logic [127:0] s_b   [MAXS];
  logic [127:0] s_exp [MAXS];
  logic         s_v   [MAXS];
  int s_n = 0;

  always #10 clk = ~clk;

  clmul_sum_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .op_i(op),
    .src_a_i(src_a), .src_b_i(src_b), .out_valid_o(out_valid), .result_o(result));

  function automatic logic is_legal(logic [4:0] o);
    return (o >= 5'd16) && (o <= 5'd19);
  endfunction

  // bit-serial model
  function automatic logic [127:0] ref_fn(logic [4:0] o, logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    int w, lanes, base, rb;
    if (!is_legal(o)) return '0;
    w = 8 << (o - 5'd16);
    lanes = 128 / w;
    for (int k = 0; k < lanes; k++) begin
      base = 128 - (k + 1) * w;
      rb   = 128 - (k / 2 + 1) * 2 * w;
      for (int j = 0; j < w; j++)
        if (a[base + j])
          for (int t = 0; t < w; t++) r[rb + j + t] = r[rb + j + t] ^ b[base + t];
    end
    return r;
  endfunction

  function automatic string mode_tag(logic [4:0] o);
    case (o)
      5'd16: return "R1";
      5'd17: return "R2";
      5'd18: return "R3";
      5'd19: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic logic msb_clear(logic [4:0] o, logic [127:0] r);
    int w2 = 16 << (o - 5'd16);
    for (int i = 0; i < 128 / w2; i++) if (r[127 - i * w2]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [4:0] o, logic [127:0] a, logic [127:0] b, logic v);
    s_op[s_n] = o; s_a[s_n] = a; s_b[s_n] = b; s_v[s_n] = v;
    s_exp[s_n] = (v && is_legal(o)) ? ref_fn(o, a, b) : '0;
    s_n++;
  endtask

  // inputs set at negedge c appear at the output by negedge c+2
  task automatic run_stream();
    for (int c = 0; c < s_n + 2; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        int k = c - 2;
        logic ev = s_v[k] && is_legal(s_op[k]);
        chk(is_legal(s_op[k]) ? "R8" : "R7", 128'(out_valid), 128'(ev));
        chk(ev ? mode_tag(s_op[k]) : (s_v[k] ? "R7" : "R10"), result, s_exp[k]);
        if (ev) chk("R6", 128'(msb_clear(s_op[k], result)), 128'd1);
      end
      if (c < s_n) begin
        in_valid = s_v[c]; op = s_op[c]; src_a = s_a[c]; src_b = s_b[c];
      end else begin
        in_valid = 1'b0;
      end
    end
    s_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9", 128'(out_valid), 128'd0);
    chk("R9", result, 128'd0);
    rst_ni = 1'b1;

    // table walk
    for (int i = 0; i < N_TAB; i++) push(TAB_OP[i], TAB_A[i], TAB_B[i], 1'b1);
    run_stream();

    // hand-computed corners
    push(5'd16, {128{1'b1}}, {8{16'hff00}}, 1'b1);
    push(5'd16, {8'h80, 120'h0}, {8'h80, 120'h0}, 1'b1);
    push(5'd19, {2{64'h8000_0000_0000_0000}}, {{64{1'b1}}, 64'h0}, 1'b1);
    push(5'd18, 128'h0, 128'h0, 1'b1);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c == 2) chk("R1", result, {8{16'h5555}});
      if (c == 3) chk("R5", result, {16'h4000, 112'h0});
      if (c == 4) chk("R4", result, 128'h7fff_ffff_ffff_ffff_8000_0000_0000_0000);
      if (c == 5) chk("R3", result, 128'h0);
      if (c < 4) begin
        in_valid = 1'b1; op = s_op[c]; src_a = s_a[c]; src_b = s_b[c];
      end else in_valid = 1'b0;
    end
    s_n = 0;

    // random streaming with bubbles and illegal codes
    for (int i = 0; i < 200; i++) begin
      logic [4:0] o = 5'd16 + 5'($urandom_range(0, 3));
      logic v = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 15) == 0) o = 5'($urandom_range(0, 15));
      push(o, {$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom}, v);
    end
    run_stream();

    // R9 reset in flight
    @(negedge clk);
    in_valid = 1'b1; op = 5'd17; src_a = {128{1'b1}}; src_b = {4{32'hffff_0000}};
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R9", 128'(out_valid), 128'd0);
    chk("R9", result, 128'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10", 128'(out_valid), 128'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule